// File: doc/BRIEF.md
# Switch global reset and init sequencer

This block holds the global control and status registers of a multi-unit switch core and runs its start-up sequence. Software reaches it through a small 16-bit register port. Setting the software reset bit pulses a soft reset into every internal unit. The block then waits until each unit reports that its initialisation is complete, and only then raises the init-ready flag. Units such as the address table and the VLAN table are seen here only as per-unit done inputs.

The same control register enables the PHY polling engine. If software sets the enable together with the reset bit, detection restarts: the two-bit polling state goes to initialising, and it moves to polling once init-ready is high and the polling engine acknowledges. Clearing the enable returns the state to disabled. A programmable watchdog sets a sticky error bit if a reset does not finish in time. A further control bit selects the accepted maximum frame length.

Top module: `swg_reset_seq`

## Requirements
- R1: While rst_n is low and just after it is released, unit_rst is 1, init_ready is 0, poll_state is 2'b00, poll_en is 0, the error bit is 0, frame_max is 1518, and register 2 reads the TMO_DEFAULT parameter. A hardware reset runs the same init sequence that a software reset runs.
- R2: A write to register 0 with bit 15 set, accepted while init_ready is 1, drives unit_rst high from the next cycle for exactly PULSE_W cycles, and init_ready goes low from that same next cycle.
- R3: Once the pulse ends, init_ready rises on the cycle after the first clock edge at which every unit_done bit is sampled 1. Done inputs are ignored during the pulse. Register 0 bit 15 reads 1 for the whole reset and 0 after it.
- R4: A write with bit 15 set while a reset is in progress is ignored and does not lengthen or restart the pulse.
- R5: Register 0 bits 13:0 and bit 14 read back the last values written to them.
- R6: Register 0 bit 10 selects frame_max: 1632 when it is 1, 1518 when it is 0, from the cycle after the write.
- R7: poll_state uses 2'b00 for disabled, 2'b01 for initialising and 2'b11 for polling, and never takes 2'b10. poll_en follows register 0 bit 14. Writing bit 14 as 0 gives 2'b00 on the next cycle. Writing it as 1 while it was 0 gives 2'b01.
- R8: An accepted reset write that also has bit 14 set puts poll_state at 2'b01 on the next cycle, even when it was 2'b11.
- R9: poll_state moves from 2'b01 to 2'b11 only at an edge where init_ready and phy_ack are both 1.
- R10: Register 2 holds the timeout limit L, with L = 0 disabling the check. Counting the start edge of a reset as edge 0, the error bit (register 1 bit 0) is set at edge L if the reset is still in progress and does not complete at that edge. Completion at edge L sets no error.
- R11: The error bit is sticky. Writing register 1 with bit 0 set clears it, and a set at the same edge wins over the clear.
- R12: Register 1 reads init_ready at bit 11, poll_state at bits 9:8 and the error at bit 0, with all other bits 0. Register 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 timeout limit, 3 unused) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| unit_done | input | NUM_UNITS | Per-unit initialisation done |
| phy_ack | input | 1 | Polling engine reports PHY detection finished |
| unit_rst | output | 1 | Soft reset to internal units |
| poll_en | output | 1 | Enable of the PHY polling engine |
| poll_state | output | 2 | Polling state (00 off, 01 init, 11 polling) |
| init_ready | output | 1 | All units initialised |
| frame_max | output | LEN_W | Accepted maximum frame length in bytes |

## Verification
The timeout detector and the reset completion can act on the same clock edge. In that case completion must win, and no error may be recorded. The bench provokes this case by raising all done inputs exactly on the edge where the count reaches the limit. It also provokes the related case where a software clear of the error bit lands on the edge that sets it, and it judges both by comparing the error bit to the cycle model on the next cycle.

// File: rtl/swg_reset_seq.sv
module swg_reset_seq #(
  parameter int NUM_UNITS = 4,
  parameter int PULSE_W = 4,
  parameter int TMO_W = 16,
  parameter logic [TMO_W-1:0] TMO_DEFAULT = 1000,
  parameter int LEN_W = 11,
  parameter int FRAME_SHORT = 1518,
  parameter int FRAME_LONG = 1632
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  input  logic [NUM_UNITS-1:0] unit_done,
  input  logic                 phy_ack,
  output logic                 unit_rst,
  output logic                 poll_en,
  output logic [1:0]           poll_state,
  output logic                 init_ready,
  output logic [LEN_W-1:0]     frame_max
);

  localparam int CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_LIM  = 2'd2;
  localparam logic [1:0] PS_OFF  = 2'b00;
  localparam logic [1:0] PS_INIT = 2'b01;
  localparam logic [1:0] PS_POLL = 2'b11;

  typedef enum logic [1:0] {PH_IDLE, PH_PULSE, PH_WAIT} phase_t;

  phase_t            phase;
  logic [CW-1:0]     pcnt;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [TMO_W-1:0]  tmo_lim;
  logic              tmo_err;
  logic [13:0]       ctrl_low;
  logic              pen;
  logic [1:0]        pstate;

  logic wr_ctrl, start, all_done, finish, busy, tmo_hit, err_clr;

  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign busy     = (phase != PH_IDLE);
  assign start    = wr_ctrl && reg_wdata[15] && !busy;
  assign all_done = &unit_done;
  assign finish   = (phase == PH_WAIT) && all_done;
  assign tmo_hit  = busy && (tmo_lim != '0) && (tmo_cnt == tmo_lim - TMO_W'(1)) && !finish;
  assign err_clr  = reg_we && (reg_addr == A_STAT) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_PULSE;
      pcnt  <= '0;
    end else begin
      case (phase)
        PH_IDLE:
          if (start) begin
            phase <= PH_PULSE;
            pcnt  <= '0;
          end
        PH_PULSE:
          if (pcnt == CW'(PULSE_W - 1)) phase <= PH_WAIT;
          else pcnt <= pcnt + 1'b1;
        PH_WAIT:
          if (all_done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_cnt <= '0;
    else if (start) tmo_cnt <= '0;
    else if (busy && (tmo_cnt != '1)) tmo_cnt <= tmo_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_err <= 1'b0;
    else if (tmo_hit) tmo_err <= 1'b1;
    else if (err_clr) tmo_err <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_low <= '0;
      pen      <= 1'b0;
      tmo_lim  <= TMO_DEFAULT;
    end else begin
      if (wr_ctrl) begin
        ctrl_low <= reg_wdata[13:0];
        pen      <= reg_wdata[14];
      end
      if (reg_we && (reg_addr == A_LIM)) tmo_lim <= reg_wdata[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pstate <= PS_OFF;
    else if (wr_ctrl && !reg_wdata[14]) pstate <= PS_OFF;
    else if (wr_ctrl && (start || !pen)) pstate <= PS_INIT;
    else if ((pstate == PS_INIT) && init_ready && phy_ack) pstate <= PS_POLL;
  end

  assign unit_rst   = (phase == PH_PULSE);
  assign init_ready = !busy;
  assign poll_en    = pen;
  assign poll_state = pstate;
  assign frame_max  = ctrl_low[10] ? LEN_W'(FRAME_LONG) : LEN_W'(FRAME_SHORT);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {busy, pen, ctrl_low};
      A_STAT:  reg_rdata = {4'b0, init_ready, 1'b0, pstate, 7'b0, tmo_err};
      A_LIM:   reg_rdata = 16'(tmo_lim);
      default: reg_rdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/swg_reset_seq_chk.sv
module swg_reset_seq_chk #(
  parameter int NUM_UNITS = 4,
  parameter int LEN_W = 11,
  parameter int FRAME_SHORT = 1518,
  parameter int FRAME_LONG = 1632
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [1:0]           reg_addr,
  input logic [15:0]          reg_wdata,
  input logic [NUM_UNITS-1:0] unit_done,
  input logic                 phy_ack,
  input logic                 unit_rst,
  input logic                 init_ready,
  input logic [1:0]           poll_state,
  input logic [LEN_W-1:0]     frame_max,
  input logic                 tmo_err
);

  p_rst_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && reg_wdata[15] && init_ready) |=> (unit_rst && !init_ready));

  p_ready_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unit_rst |-> !init_ready);

  p_ready_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_ready && !unit_rst && (&unit_done)) |=> init_ready);

  p_ready_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ready) |-> $past(&unit_done));

  p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_ready && !unit_rst && !(&unit_done) && reg_we && reg_addr == 2'd0 && reg_wdata[15])
    |=> !unit_rst);

  p_frame_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=>
    (frame_max == ($past(reg_wdata[10]) ? LEN_W'(FRAME_LONG) : LEN_W'(FRAME_SHORT))));

  p_poll_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && !reg_wdata[14]) |=> (poll_state == 2'b00));

  p_poll_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_state != 2'b10);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && reg_wdata[15] && reg_wdata[14] && init_ready)
    |=> (poll_state == 2'b01));

  p_poll_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_state == 2'b11 && $past(poll_state) == 2'b01) |-> ($past(init_ready) && $past(phy_ack)));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !(reg_we && reg_addr == 2'd1 && reg_wdata[0])) |=> tmo_err);

endmodule

bind swg_reset_seq swg_reset_seq_chk #(
  .NUM_UNITS(NUM_UNITS), .LEN_W(LEN_W), .FRAME_SHORT(FRAME_SHORT), .FRAME_LONG(FRAME_LONG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .unit_done(unit_done), .phy_ack(phy_ack), .unit_rst(unit_rst), .init_ready(init_ready),
  .poll_state(poll_state), .frame_max(frame_max), .tmo_err(tmo_err)
);

// File: tb/sim_swg_reset_seq.sv
module sim_swg_reset_seq;
  localparam int NU = 4;
  localparam int PW = 4;
  localparam int DEF_LIM = 200;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [NU-1:0] unit_done = '0;
  logic phy_ack = 1'b0;
  logic unit_rst, poll_en, init_ready;
  logic [1:0] poll_state;
  logic [10:0] frame_max;

  swg_reset_seq #(.NUM_UNITS(NU), .PULSE_W(PW), .TMO_DEFAULT(16'(DEF_LIM))) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .unit_done(unit_done), .phy_ack(phy_ack), .unit_rst(unit_rst),
    .poll_en(poll_en), .poll_state(poll_state), .init_ready(init_ready), .frame_max(frame_max)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_phase;  // 0 idle, 1 pulse, 2 wait
  int m_left;
  int m_cnt;
  int m_lim;
  bit m_err;
  bit m_pen;
  bit [13:0] m_low;
  bit [1:0] m_ps;
  bit cmp_on = 0;

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {(m_phase != 0), m_pen, m_low};
      2'd1: return {4'b0, (m_phase == 0), 1'b0, m_ps, 7'b0, m_err};
      2'd2: return 16'(m_lim);
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit wr0, start, fin, hit, clr;
    if (!rst_n) begin
      m_phase = 1; m_left = PW; m_cnt = 0; m_lim = DEF_LIM;
      m_err = 0; m_pen = 0; m_low = '0; m_ps = 2'b00;
    end else begin
      wr0   = reg_we && reg_addr == 2'd0;
      start = wr0 && reg_wdata[15] && m_phase == 0;
      fin   = m_phase == 2 && (&unit_done);
      hit   = m_phase != 0 && m_lim != 0 && m_cnt == m_lim - 1 && !fin;
      clr   = reg_we && reg_addr == 2'd1 && reg_wdata[0];
      if (wr0 && !reg_wdata[14]) m_ps = 2'b00;
      else if (wr0 && (start || !m_pen)) m_ps = 2'b01;
      else if (m_ps == 2'b01 && m_phase == 0 && phy_ack) m_ps = 2'b11;
      if (hit) m_err = 1;
      else if (clr) m_err = 0;
      if (start) m_cnt = 0;
      else if (m_phase != 0 && m_cnt != 65535) m_cnt++;
      case (m_phase)
        0: if (start) begin m_phase = 1; m_left = PW; end
        1: if (m_left == 1) m_phase = 2; else m_left--;
        default: if (&unit_done) m_phase = 0;
      endcase
      if (wr0) begin m_low = reg_wdata[13:0]; m_pen = reg_wdata[14]; end
      if (reg_we && reg_addr == 2'd2) m_lim = int'(reg_wdata);
    end
    #3;
    if (cmp_on) begin
      check("R2 unit_rst", unit_rst, (m_phase == 1));
      check("R3 init_ready", init_ready, (m_phase == 0));
      check("R7 poll_state", poll_state, m_ps);
      check("R7 poll_en", poll_en, m_pen);
      check("R6 frame_max", frame_max, m_low[10] ? 1632 : 1518);
      check("R12 reg_rdata", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 16'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !init_ready; i++) @(negedge clk);
  endtask

  task automatic wait_cnt(input int target);
    for (int i = 0; i < 200 && !(m_cnt == target && m_phase == 2); i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    check("R1 unit_rst", unit_rst, 1);
    check("R1 init_ready", init_ready, 0);
    check("R1 poll_state", poll_state, 0);
    check("R1 poll_en", poll_en, 0);
    check("R1 frame", frame_max, 1518);
    rd(2'd2, d); check("R1 limit default", d, DEF_LIM);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    unit_done = '1;
    wait_ready();
    check("R1 power-up init done", init_ready, 1);

    // R5 / R6 readback and frame select
    wr(2'd0, 16'h0523);
    rd(2'd0, d); check("R5 ctrl readback", d, 16'h0523);
    check("R6 long frame", frame_max, 1632);

    // R2 pulse width with done held high (ignored during pulse, R3)
    wr(2'd0, 16'h8523);
    n = 0;
    while (unit_rst && n < 50) begin n++; @(negedge clk); end
    check("R2 pulse length", n, PW);
    rd(2'd0, d); check("R3 bit15 busy", d[15], 1);
    check("R3 not yet ready", init_ready, 0);
    @(negedge clk);
    check("R3 ready after done", init_ready, 1);
    rd(2'd0, d); check("R5 ctrl kept, R3 bit15 cleared", d, 16'h0523);

    // R4 reset request during reset ignored
    unit_done = '0;
    wr(2'd0, 16'h8523);
    n = 1;
    wr(2'd0, 16'h8523);
    while (unit_rst && n < 50) begin n++; @(negedge clk); end
    check("R4 pulse not restarted", n, PW);
    repeat (3) @(negedge clk);
    check("R3 waits for done", init_ready, 0);
    unit_done = 4'b0111;
    @(negedge clk);
    check("R3 partial done", init_ready, 0);
    unit_done = '1;
    @(negedge clk);
    check("R3 all done", init_ready, 1);

    // R7 / R9 enable without reset
    wr(2'd0, 16'h4523);
    check("R7 enable gives init", poll_state, 2'b01);
    repeat (3) @(negedge clk);
    check("R9 no ack stays init", poll_state, 2'b01);
    phy_ack = 1'b1;
    @(negedge clk);
    check("R9 ack moves to poll", poll_state, 2'b11);

    // R8 reset with enable restarts detection
    unit_done = '0;
    wr(2'd0, 16'hC523);
    check("R8 restart to init", poll_state, 2'b01);
    repeat (PW + 3) @(negedge clk);
    check("R9 held while not ready", poll_state, 2'b01);
    unit_done = '1;
    wait_ready();
    @(negedge clk);
    check("R9 poll after ready", poll_state, 2'b11);

    // R7 disable
    wr(2'd0, 16'h0523);
    check("R7 disable", poll_state, 2'b00);
    phy_ack = 1'b0;

    // R10 timeout and R11 sticky / clear
    wr(2'd2, 16'd6);
    unit_done = '0;
    wr(2'd0, 16'h8523);
    repeat (12) @(negedge clk);
    rd(2'd1, d); check("R10 timeout error", d[0], 1);
    unit_done = '1;
    wait_ready();
    rd(2'd1, d); check("R11 error sticky", d[0], 1);
    wr(2'd1, 16'h0001);
    rd(2'd1, d); check("R11 error cleared", d[0], 0);

    // R10 completion on the limit edge wins
    wr(2'd2, 16'd8);
    unit_done = '0;
    wr(2'd0, 16'h8523);
    wait_cnt(7);
    unit_done = '1;
    @(negedge clk);
    rd(2'd1, d); check("R10 completion beats timeout", d[0], 0);
    check("R10 ready at limit edge", init_ready, 1);

    // R11 set beats clear on the same edge
    unit_done = '0;
    wr(2'd0, 16'h8523);
    wait_cnt(6);
    @(negedge clk);
    wr(2'd1, 16'h0001);
    rd(2'd1, d); check("R11 set wins over clear", d[0], 1);
    unit_done = '1;
    wait_ready();
    wr(2'd1, 16'h0001);

    // R10 limit zero disables
    wr(2'd2, 16'd0);
    unit_done = '0;
    wr(2'd0, 16'h8523);
    repeat (30) @(negedge clk);
    rd(2'd1, d); check("R10 limit zero no error", d[0], 0);
    unit_done = '1;
    wait_ready();

    // R12 layout and unused address
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); check("R12 addr3 reads zero", d, 16'h0);
    rd(2'd1, d); check("R12 status layout", d, 16'h0800);
    rd(2'd0, d); check("R12 addr3 write no effect", d, 16'h0523);
    rd(2'd2, d); check("R12 limit unchanged", d, 16'h0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule